// File: doc/BRIEF.md
# Single-Transfer Address Generator

This block forms the memory address for single load/store transfers of a DSP datapath that go over the shared CPU data bus. Such a transfer can reach any memory space, and it can carry a 16-bit word or a 32-bit longword. Each request names one of four pointer registers, an addressing mode and an operand size. The block returns the bus address and size, and it holds them steady with a stall indication until the shared bus grants the access. On the granted cycle it returns the updated pointer value together with a write enable, so that the register file outside the block can store it.

Four modes are offered. Three of them update after the access: leave the pointer alone, step it by the operand size, or add the single index register. The fourth updates before the access: it steps the pointer down by the operand size and uses the lowered value as the address. Address arithmetic simply wraps at the address width. No modulo boundary is ever applied on this path. A longword access to an address that is not a multiple of four is refused with an address-error pulse.

Top module: `sta_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bus_req`, `stall`, `addr_err` and `ptr_we` are all low.
- R2: `req_mode` encodes 0 = keep, 1 = post-increment, 2 = post-add index, 3 = pre-decrement. For modes 0 to 2 `bus_addr` equals the selected pointer. For mode 3 it equals the pointer minus the step. The step is 2 for a word and 4 for a longword.
- R3: On completion the written pointer value is pointer+step for mode 1, pointer+`idx_val` for mode 2 and pointer−step for mode 3. Mode 0 writes nothing.
- R4: `req_long` = 1 selects a 32-bit transfer and 0 a 16-bit one. `bus_long` repeats the size of the transfer being presented.
- R5: While a transfer is presented and `bus_grant` is low, `stall` is high, and `bus_req`, `bus_addr` and `bus_long` stay unchanged.
- R6: The pointer write happens only in the cycle where `bus_grant` is high for that transfer. It happens once per transfer, with `ptr_wsel` equal to the requesting `req_sel`.
- R7: A longword request whose address has bits [1:0] not equal to 00 raises `addr_err` for one cycle. It raises no `bus_req` and no pointer write, and the pointer keeps its value.
- R8: Address and pointer arithmetic wrap modulo 2^AW with no other boundary.
- R9: A new request accepted in the cycle another transfer completes uses the value just written if it selects the same pointer.
- R10: A request is taken when `req_valid` is high and `stall` is low. It appears on the bus outputs (or as `addr_err`) in the next cycle. A request offered while `stall` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_sel | input | SELW | Pointer select (0..NPTR-1) |
| req_mode | input | 2 | Addressing mode |
| req_long | input | 1 | 1 = longword, 0 = word |
| ptr_bank | input | NPTR*AW | Current pointer values, pointer k at bits [k*AW +: AW] |
| idx_val | input | AW | Index register value |
| bus_grant | input | 1 | Shared bus granted this cycle |
| bus_req | output | 1 | Transfer presented on the bus |
| bus_addr | output | AW | Transfer address |
| bus_long | output | 1 | Transfer size |
| stall | output | 1 | Waiting for the shared bus |
| addr_err | output | 1 | Misaligned longword refused |
| ptr_we | output | 1 | Pointer write enable |
| ptr_wsel | output | SELW | Pointer being written |
| ptr_wdata | output | AW | Updated pointer value |

## Verification
The bench goes after a pointer that is re-used in the very cycle its previous transfer completes. Without the bypass, the second access would read the stale value and the pointer would end one step short. It also steps pointers across address zero in both directions and checks that they wrap instead of saturating or being clipped by a modulo window. Long runs with the grant low test the hold. A design that re-sampled its inputs during a stall would change the address, or would write the pointer before the grant came. Misaligned longwords, including one produced by a pre-decrement, must leave the pointer untouched and raise no bus request.

// File: rtl/sta_pkg.sv
package sta_pkg;
   typedef enum logic [1:0] {
      AM_KEEP   = 2'd0,
      AM_INC    = 2'd1,
      AM_INDEX  = 2'd2,
      AM_PREDEC = 2'd3
   } am_mode_e;
endpackage

// File: rtl/sta_ptr_pick.sv
module sta_ptr_pick #(
   parameter int AW     = 32,
   parameter int NPTR   = 4,
   parameter bit FWD_EN = 1'b1,
   localparam int SELW  = $clog2(NPTR)
) (
   input  logic [NPTR*AW-1:0] bank,
   input  logic [SELW-1:0]    sel,
   input  logic               fwd_we,
   input  logic [SELW-1:0]    fwd_sel,
   input  logic [AW-1:0]      fwd_data,
   output logic [AW-1:0]      base
);
   logic [AW-1:0] raw;

   always_comb begin
      raw = '0;
      for (int k = 0; k < NPTR; k++) begin
         if (sel == SELW'(k)) raw = bank[k*AW +: AW];
      end
   end

   generate
      if (FWD_EN) begin : g_bypass
         assign base = (fwd_we && fwd_sel == sel) ? fwd_data : raw;
      end else begin : g_direct
         logic unused_fwd;
         assign unused_fwd = ^{fwd_we, fwd_sel, fwd_data};
         assign base = raw;
      end
   endgenerate
endmodule

// File: rtl/sta_ea_calc.sv
module sta_ea_calc
   import sta_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  am_mode_e      mode,
   input  logic          is_long,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] wb,
   output logic          wb_en,
   output logic          misal
);
   logic [AW-1:0] step;
   logic [AW-1:0] down;

   assign step = is_long ? AW'(4) : AW'(2);
   assign down = base - step;

   always_comb begin
      addr  = base;
      wb    = base;
      wb_en = 1'b1;
      unique case (mode)
         AM_KEEP:   wb_en = 1'b0;
         AM_INC:    wb    = base + step;
         AM_INDEX:  wb    = base + index;
         AM_PREDEC: begin
            addr = down;
            wb   = down;
         end
      endcase
   end

   assign misal = is_long && (addr[1:0] != 2'b00);
endmodule

// File: rtl/sta_slot.sv
module sta_slot #(
   parameter int AW   = 32,
   parameter int SELW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            clear,
   input  logic [AW-1:0]   d_addr,
   input  logic [AW-1:0]   d_wb,
   input  logic [SELW-1:0] d_sel,
   input  logic            d_long,
   input  logic            d_we,
   input  logic            d_err,
   output logic            q_valid,
   output logic [AW-1:0]   q_addr,
   output logic [AW-1:0]   q_wb,
   output logic [SELW-1:0] q_sel,
   output logic            q_long,
   output logic            q_we,
   output logic            q_err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_addr  <= '0;
         q_wb    <= '0;
         q_sel   <= '0;
         q_long  <= 1'b0;
         q_we    <= 1'b0;
         q_err   <= 1'b0;
      end else if (load) begin
         q_valid <= 1'b1;
         q_addr  <= d_addr;
         q_wb    <= d_wb;
         q_sel   <= d_sel;
         q_long  <= d_long;
         q_we    <= d_we && !d_err;
         q_err   <= d_err;
      end else if (clear) begin
         q_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/sta_addr_gen.sv
module sta_addr_gen
   import sta_pkg::*;
#(
   parameter int AW     = 32,
   parameter int NPTR   = 4,
   parameter bit FWD_EN = 1'b1,
   localparam int SELW  = $clog2(NPTR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [SELW-1:0]    req_sel,
   input  logic [1:0]         req_mode,
   input  logic               req_long,
   input  logic [NPTR*AW-1:0] ptr_bank,
   input  logic [AW-1:0]      idx_val,
   input  logic               bus_grant,
   output logic               bus_req,
   output logic [AW-1:0]      bus_addr,
   output logic               bus_long,
   output logic               stall,
   output logic               addr_err,
   output logic               ptr_we,
   output logic [SELW-1:0]    ptr_wsel,
   output logic [AW-1:0]      ptr_wdata
);
   logic          s_valid, s_long, s_we, s_err;
   logic [AW-1:0] s_addr, s_wb;
   logic [SELW-1:0] s_sel;
   logic [AW-1:0] base, n_addr, n_wb;
   logic          n_we, n_err;
   logic          done, take;

   assign done = s_valid && (s_err || bus_grant);
   assign take = req_valid && (!s_valid || done);

   assign bus_req   = s_valid && !s_err;
   assign bus_addr  = s_addr;
   assign bus_long  = s_long;
   assign stall     = bus_req && !bus_grant;
   assign addr_err  = s_valid && s_err;
   assign ptr_we    = bus_req && bus_grant && s_we;
   assign ptr_wsel  = s_sel;
   assign ptr_wdata = s_wb;

   sta_ptr_pick #(.AW(AW), .NPTR(NPTR), .FWD_EN(FWD_EN)) u_pick (
      .bank(ptr_bank), .sel(req_sel),
      .fwd_we(ptr_we), .fwd_sel(s_sel), .fwd_data(s_wb),
      .base(base)
   );

   sta_ea_calc #(.AW(AW)) u_calc (
      .base(base), .index(idx_val), .mode(am_mode_e'(req_mode)),
      .is_long(req_long),
      .addr(n_addr), .wb(n_wb), .wb_en(n_we), .misal(n_err)
   );

   sta_slot #(.AW(AW), .SELW(SELW)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(take), .clear(done),
      .d_addr(n_addr), .d_wb(n_wb), .d_sel(req_sel), .d_long(req_long),
      .d_we(n_we), .d_err(n_err),
      .q_valid(s_valid), .q_addr(s_addr), .q_wb(s_wb), .q_sel(s_sel),
      .q_long(s_long), .q_we(s_we), .q_err(s_err)
   );
endmodule

// File: rtl/sta_addr_gen_chk.sv
module sta_addr_gen_chk #(
   parameter int AW   = 32,
   parameter int SELW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          bus_req,
   input logic [AW-1:0] bus_addr,
   input logic          bus_long,
   input logic          stall,
   input logic          addr_err,
   input logic          ptr_we
);
   p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> bus_req && $stable(bus_addr) && $stable(bus_long));

   p_long_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_long) |-> (bus_addr[1:0] == 2'b00));

   p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> (!bus_req && !ptr_we));

   p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_err && !req_valid) |=> !addr_err);

   p_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !stall) |=> (bus_req || addr_err));
endmodule

bind sta_addr_gen sta_addr_gen_chk #(.AW(AW), .SELW(SELW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_req(bus_req),
   .bus_addr(bus_addr), .bus_long(bus_long), .stall(stall),
   .addr_err(addr_err), .ptr_we(ptr_we)
);

// File: tb/sim_sta_addr_gen.sv
module sim_sta_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_sel = '0;
   logic [1:0]  req_mode = '0;
   logic        req_long = 1'b0;
   logic [31:0] idx_val = 32'h40;
   logic        bus_grant = 1'b0;
   logic [127:0] ptr_bank;
   logic        bus_req, bus_long, stall, addr_err, ptr_we;
   logic [31:0] bus_addr, ptr_wdata;
   logic [1:0]  ptr_wsel;

   logic [31:0] rf [4];
   logic [31:0] mb [4];
   logic        m_valid = 1'b0, m_err = 1'b0, m_we = 1'b0, m_long = 1'b0;
   logic [31:0] m_addr = '0, m_wb = '0;
   int          m_sel = 0;
   int          checks = 0, failures = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   sta_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_mode(req_mode), .req_long(req_long), .ptr_bank(ptr_bank),
      .idx_val(idx_val), .bus_grant(bus_grant), .bus_req(bus_req),
      .bus_addr(bus_addr), .bus_long(bus_long), .stall(stall),
      .addr_err(addr_err), .ptr_we(ptr_we), .ptr_wsel(ptr_wsel),
      .ptr_wdata(ptr_wdata)
   );

   assign ptr_bank = {rf[3], rf[2], rf[1], rf[0]};

   function automatic logic [31:0] init_val(int k);
      case (k)
         0: return 32'h0000_1000;
         1: return 32'h0000_0002;
         2: return 32'h0000_2000;
         default: return 32'hFFFF_FFF8;
      endcase
   endfunction

   // register file owned by the bench, written only through the block
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) rf[k] <= init_val(k);
      end else if (ptr_we) begin
         rf[ptr_wsel] <= ptr_wdata;
      end
   end

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 1'b0;
         for (int k = 0; k < 4; k++) mb[k] = init_val(k);
      end else begin
         bit fin;
         fin = m_valid && (m_err || bus_grant);
         if (fin && !m_err && m_we) mb[m_sel] = m_wb;
         if (req_valid && (!m_valid || fin)) begin
            logic [31:0] p, st;
            p  = mb[req_sel];
            st = req_long ? 32'd4 : 32'd2;
            m_addr = (req_mode == 2'd3) ? p - st : p;
            case (req_mode)
               2'd1: m_wb = p + st;
               2'd2: m_wb = p + idx_val;
               2'd3: m_wb = p - st;
               default: m_wb = p;
            endcase
            m_long  = req_long;
            m_sel   = int'(req_sel);
            m_err   = req_long && (m_addr[1:0] != 2'b00);
            m_we    = (req_mode != 2'd0) && !m_err;
            m_valid = 1'b1;
         end else if (fin) begin
            m_valid = 1'b0;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, 3 ns after the falling edge
   always @(negedge clk) begin
      #3;
      if (rst_n && !finished) begin
         logic e_req;
         e_req = m_valid && !m_err;
         chk("R10 bus_req", 32'(bus_req), 32'(e_req));
         chk("R5 stall", 32'(stall), 32'(e_req && !bus_grant));
         chk("R7 addr_err", 32'(addr_err), 32'(m_valid && m_err));
         chk("R6 ptr_we", 32'(ptr_we), 32'(e_req && bus_grant && m_we));
         if (e_req) begin
            chk("R2 bus_addr", bus_addr, m_addr);
            chk("R4 bus_long", 32'(bus_long), 32'(m_long));
         end
         if (e_req && bus_grant && m_we) begin
            chk("R6 ptr_wsel", 32'(ptr_wsel), 32'(m_sel));
            chk("R3 ptr_wdata", ptr_wdata, m_wb);
         end
         for (int k = 0; k < 4; k++) chk("R9 pointer file", rf[k], mb[k]);
      end
   end

   task automatic drive(bit v, int sel, int mode, bit lng, bit gnt);
      @(negedge clk);
      req_valid = v;
      req_sel   = 2'(sel);
      req_mode  = 2'(mode);
      req_long  = lng;
      bus_grant = gnt;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b0, 1'b1);
   endtask

   task automatic summary;
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      #3;
      chk("R1 reset bus_req", 32'(bus_req), 32'd0);
      chk("R1 reset stall", 32'(stall), 32'd0);
      chk("R1 reset addr_err", 32'(addr_err), 32'd0);
      chk("R1 reset ptr_we", 32'(ptr_we), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #3;
      chk("R1 first cycle bus_req", 32'(bus_req), 32'd0);
      chk("R1 first cycle ptr_we", 32'(ptr_we), 32'd0);

      // back-to-back longword increments on one pointer across zero
      drive(1'b1, 3, 1, 1'b1, 1'b1);
      drive(1'b1, 3, 1, 1'b1, 1'b1);
      drive(1'b1, 3, 0, 1'b1, 1'b1);
      idle(3);
      chk("R8 R9 wrap with bypass", rf[3], 32'h0000_0000);

      // pre-decrement longword gives a misaligned address
      drive(1'b1, 1, 3, 1'b1, 1'b1);
      idle(2);
      chk("R7 pointer kept", rf[1], 32'h0000_0002);

      // pre-decrement words down through zero
      drive(1'b1, 1, 3, 1'b0, 1'b1);
      drive(1'b1, 1, 3, 1'b0, 1'b1);
      idle(3);
      chk("R8 decrement wrap", rf[1], 32'hFFFF_FFFE);

      // index add held off by a busy bus
      drive(1'b1, 0, 2, 1'b0, 1'b0);
      drive(1'b1, 2, 1, 1'b1, 1'b0);
      drive(1'b0, 0, 0, 1'b0, 1'b0);
      drive(1'b0, 0, 0, 1'b0, 1'b0);
      drive(1'b0, 0, 0, 1'b0, 1'b1);
      idle(2);
      chk("R3 index add", rf[0], 32'h0000_1040);
      chk("R10 stalled request ignored", rf[2], 32'h0000_2000);

      // mixed traffic
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 16) == 0) idx_val = $urandom & 32'hFFFF_FFFE;
         drive(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 4),
               1'($urandom % 2), ($urandom % 3) != 0);
      end
      idle(4);
      summary();
   end
endmodule